// File: doc/BRIEF.md
# Checkpointed Register Alias Table

This block holds the speculative mapping from architectural registers to physical register names for a renaming front end. Each architectural register has one table entry, and each entry holds a physical register name. Several read ports look up mappings, and several write ports install new mappings, in every cycle. When two write ports in one cycle name the same architectural register, the port with the higher index represents the later instruction, and its value is the one kept.

Beside the live table sits a shallow stack of full snapshots, kept per bit as a bidirectional shift register. When the front end renames an instruction that opens a speculation window, such as a predicted branch, it asks for a snapshot. The new snapshot enters at the young end and the older ones shift one place deeper. When the oldest speculating instruction commits, its snapshot is released. On a misprediction the front end names a snapshot by its age rank. That snapshot is copied into the live table in a single cycle, and the snapshot together with every younger one is discarded by shifting the stack toward the young end.

Snapshots are addressed by age rank counted from the youngest: rank 0 is the youngest live snapshot and rank `ckpt_count-1` is the oldest.

Top module: `rat_ckpt_table`

## Requirements
- R1: After reset, entry i holds physical name i for every architectural register, `ckpt_count` is 0 and `ckpt_full` is 0.
- R2: Each read port returns, without delay, the mapping held at the start of the cycle. A write in the same cycle becomes visible only after the next rising clock edge.
- R3: An enabled write port sets the named entry at the next edge. When several enabled ports name the same entry in one cycle, the highest-indexed port wins.
- R4: A take request while not full stores a snapshot that includes that cycle's writes, makes it rank 0, and raises `ckpt_count` by one.
- R5: `ckpt_full` is 1 exactly when `ckpt_count` equals the checkpoint depth (4 by default). A take request while full has no effect on the count or on the snapshots.
- R6: A restore request with rank k below `ckpt_count` loads snapshot k into the live table at the next edge and lowers `ckpt_count` by k+1. Writes and take requests in the same cycle are ignored.
- R7: A restore request with rank k not below `ckpt_count` is ignored, and writes in that cycle apply normally.
- R8: A release request drops the oldest snapshot and lowers `ckpt_count` by one, while the younger snapshots keep their ranks. A release while `ckpt_count` is 0 is ignored. A release together with an accepted take leaves the count unchanged.
- R9: A release in the same cycle as an accepted restore of rank k sets `ckpt_count` to the greater of 0 and `ckpt_count`-k-2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_arch | input | NUM_RD*AW | Architectural register per read port, port r at bits r*AW |
| rd_phys | output | NUM_RD*PW | Mapped physical name per read port |
| wr_en | input | NUM_WR | Write enable per write port |
| wr_arch | input | NUM_WR*AW | Architectural register per write port |
| wr_phys | input | NUM_WR*PW | New physical name per write port |
| ckpt_take | input | 1 | Store a snapshot of the table |
| ckpt_release | input | 1 | Release the oldest snapshot |
| restore_en | input | 1 | Restore the live table from a snapshot |
| restore_idx | input | IW | Age rank of the snapshot to restore, 0 = youngest |
| ckpt_full | output | 1 | Every snapshot slot is occupied |
| ckpt_count | output | CW | Number of live snapshots |

## Verification
The assertions check the count behaviour on every cycle. They cover the increment on an accepted take, the hold on a blocked take, the decrement on a release, the drop by k+1 on a valid restore and the count bound. They also check that a write shows up on a read port one cycle later, and that reads stay stable when nothing writes. Snapshot content can only be shown by the bench's scenarios. These include which snapshot a restore of a given rank brings back, whether same-cycle writes are part of a snapshot, whether writes are blocked during a restore, and whether younger ranks survive a release.

// File: rtl/rat_pkg.sv
package rat_pkg;

    typedef enum logic [1:0] {
        STK_HOLD = 2'd0,
        STK_PUSH = 2'd1,
        STK_DROP = 2'd2
    } stk_op_e;

endpackage

// File: rtl/rat_wr_merge.sv
module rat_wr_merge #(
    parameter int NUM_ARCH = 32,
    parameter int PW       = 7,
    parameter int NUM_WR   = 2,
    localparam int AW      = $clog2(NUM_ARCH),
    localparam int TW      = NUM_ARCH * PW
) (
    input  logic [TW-1:0]        map_in,
    input  logic [NUM_WR-1:0]    wr_en,
    input  logic [NUM_WR*AW-1:0] wr_arch,
    input  logic [NUM_WR*PW-1:0] wr_phys,
    output logic [TW-1:0]        map_out
);

    // Ports are applied in ascending order so the highest index wins.
    always_comb begin
        map_out = map_in;
        for (int p = 0; p < NUM_WR; p++) begin
            if (wr_en[p]) begin
                map_out[int'(wr_arch[p*AW +: AW])*PW +: PW] = wr_phys[p*PW +: PW];
            end
        end
    end

endmodule

// File: rtl/rat_ckpt_stack.sv
module rat_ckpt_stack
    import rat_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int WIDTH = 224,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int NW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  stk_op_e          op,
    input  logic [NW-1:0]    drop_n,
    input  logic [WIDTH-1:0] push_data,
    input  logic [IW-1:0]    rd_idx,
    output logic [WIDTH-1:0] rd_data
);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] slot;
    } stk_t;

    stk_t stk_d, stk_q;

    // Slot 0 is the youngest snapshot; push shifts toward the old end,
    // drop shifts toward the young end by drop_n places.
    always_comb begin
        stk_d = stk_q;
        unique case (op)
            STK_PUSH: begin
                stk_d.slot[0] = push_data;
                for (int j = 1; j < DEPTH; j++) begin
                    stk_d.slot[j] = stk_q.slot[j-1];
                end
            end
            STK_DROP: begin
                for (int j = 0; j < DEPTH; j++) begin
                    if (j + int'(drop_n) < DEPTH) begin
                        stk_d.slot[j] = stk_q.slot[j + int'(drop_n)];
                    end else begin
                        stk_d.slot[j] = '0;
                    end
                end
            end
            default: stk_d = stk_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stk_q <= '0;
        end else begin
            stk_q <= stk_d;
        end
    end

    assign rd_data = stk_q.slot[rd_idx];

endmodule

// File: rtl/rat_ckpt_table.sv
module rat_ckpt_table
    import rat_pkg::*;
#(
    parameter int NUM_ARCH = 32,
    parameter int PW       = 7,
    parameter int NUM_RD   = 2,
    parameter int NUM_WR   = 2,
    parameter int NUM_CKPT = 4,
    localparam int AW      = $clog2(NUM_ARCH),
    localparam int IW      = (NUM_CKPT > 1) ? $clog2(NUM_CKPT) : 1,
    localparam int CW      = $clog2(NUM_CKPT + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RD*AW-1:0] rd_arch,
    output logic [NUM_RD*PW-1:0] rd_phys,
    input  logic [NUM_WR-1:0]    wr_en,
    input  logic [NUM_WR*AW-1:0] wr_arch,
    input  logic [NUM_WR*PW-1:0] wr_phys,
    input  logic                 ckpt_take,
    input  logic                 ckpt_release,
    input  logic                 restore_en,
    input  logic [IW-1:0]        restore_idx,
    output logic                 ckpt_full,
    output logic [CW-1:0]        ckpt_count
);

    localparam int TW = NUM_ARCH * PW;

    typedef struct packed {
        logic [TW-1:0] map;
        logic [CW-1:0] cnt;
    } state_t;

    state_t        st_d, st_q;
    logic [TW-1:0] merged;
    logic [TW-1:0] snap;
    stk_op_e       stk_op;
    logic [CW-1:0] drop_n;

    function automatic logic [TW-1:0] ident_map();
        logic [TW-1:0] m;
        for (int i = 0; i < NUM_ARCH; i++) begin
            m[i*PW +: PW] = PW'(i);
        end
        return m;
    endfunction

    rat_wr_merge #(
        .NUM_ARCH(NUM_ARCH),
        .PW      (PW),
        .NUM_WR  (NUM_WR)
    ) i_merge (
        .map_in (st_q.map),
        .wr_en  (wr_en),
        .wr_arch(wr_arch),
        .wr_phys(wr_phys),
        .map_out(merged)
    );

    rat_ckpt_stack #(
        .DEPTH(NUM_CKPT),
        .WIDTH(TW)
    ) i_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (stk_op),
        .drop_n   (drop_n),
        .push_data(merged),
        .rd_idx   (restore_idx),
        .rd_data  (snap)
    );

    always_comb begin
        logic restore_ok;
        logic take_ok;
        logic rel_ok;
        int   left;

        st_d       = st_q;
        stk_op     = STK_HOLD;
        drop_n     = '0;
        restore_ok = restore_en && (int'(restore_idx) < int'(st_q.cnt));
        take_ok    = ckpt_take && (int'(st_q.cnt) != NUM_CKPT);
        rel_ok     = ckpt_release && (st_q.cnt != '0);
        left       = int'(st_q.cnt);

        if (restore_ok) begin
            st_d.map = snap;
            stk_op   = STK_DROP;
            drop_n   = CW'(int'(restore_idx) + 1);
            left     = int'(st_q.cnt) - int'(restore_idx) - 1;
            if (ckpt_release && left > 0) begin
                left = left - 1;
            end
        end else begin
            st_d.map = merged;
            if (take_ok) begin
                stk_op = STK_PUSH;
                left   = left + 1;
            end
            if (rel_ok) begin
                left = left - 1;
            end
        end
        st_d.cnt = CW'(left);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.map <= ident_map();
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
        assign rd_phys[r*PW +: PW] = st_q.map[int'(rd_arch[r*AW +: AW])*PW +: PW];
    end

    assign ckpt_count = st_q.cnt;
    assign ckpt_full  = (int'(st_q.cnt) == NUM_CKPT);

endmodule

// File: rtl/rat_ckpt_table_chk.sv
module rat_ckpt_table_chk #(
    parameter int NUM_ARCH = 32,
    parameter int PW       = 7,
    parameter int NUM_RD   = 2,
    parameter int NUM_WR   = 2,
    parameter int NUM_CKPT = 4,
    localparam int AW      = $clog2(NUM_ARCH),
    localparam int IW      = (NUM_CKPT > 1) ? $clog2(NUM_CKPT) : 1,
    localparam int CW      = $clog2(NUM_CKPT + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_RD*AW-1:0] rd_arch,
    input logic [NUM_RD*PW-1:0] rd_phys,
    input logic [NUM_WR-1:0]    wr_en,
    input logic [NUM_WR*AW-1:0] wr_arch,
    input logic [NUM_WR*PW-1:0] wr_phys,
    input logic                 ckpt_take,
    input logic                 ckpt_release,
    input logic                 restore_en,
    input logic [IW-1:0]        restore_idx,
    input logic                 ckpt_full,
    input logic [CW-1:0]        ckpt_count
);

    localparam int LW = NUM_WR - 1;

    logic          valid_rs;
    logic [AW-1:0] ra0;
    logic [PW-1:0] rp0;
    logic [AW-1:0] wa_hi;
    logic [PW-1:0] wp_hi;

    assign valid_rs = restore_en && (int'(restore_idx) < int'(ckpt_count));
    assign ra0      = rd_arch[AW-1:0];
    assign rp0      = rd_phys[PW-1:0];
    assign wa_hi    = wr_arch[LW*AW +: AW];
    assign wp_hi    = wr_phys[LW*PW +: PW];

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ckpt_count) <= NUM_CKPT); // R5

    AST_FULL_BLOCKS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_full && ckpt_take && !restore_en && !ckpt_release |=> $stable(ckpt_count)); // R5

    AST_TAKE_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_take && !ckpt_full && !restore_en && !ckpt_release
        |=> int'(ckpt_count) == int'($past(ckpt_count)) + 1); // R4

    AST_RELEASE_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_release && ckpt_count != '0 && !ckpt_take && !restore_en
        |=> int'(ckpt_count) == int'($past(ckpt_count)) - 1); // R8

    AST_RESTORE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_rs && !ckpt_release
        |=> int'(ckpt_count) == int'($past(ckpt_count)) - int'($past(restore_idx)) - 1); // R6

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en[LW] && !restore_en && ra0 == wa_hi
        |=> (!$stable(ra0) || rp0 == $past(wp_hi))); // R3

    AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en == '0 && !restore_en
        |=> (!$stable(ra0) || $stable(rp0))); // R2

endmodule

bind rat_ckpt_table rat_ckpt_table_chk #(
    .NUM_ARCH(NUM_ARCH),
    .PW      (PW),
    .NUM_RD  (NUM_RD),
    .NUM_WR  (NUM_WR),
    .NUM_CKPT(NUM_CKPT)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_arch     (rd_arch),
    .rd_phys     (rd_phys),
    .wr_en       (wr_en),
    .wr_arch     (wr_arch),
    .wr_phys     (wr_phys),
    .ckpt_take   (ckpt_take),
    .ckpt_release(ckpt_release),
    .restore_en  (restore_en),
    .restore_idx (restore_idx),
    .ckpt_full   (ckpt_full),
    .ckpt_count  (ckpt_count)
);

// File: tb/test_rat_ckpt_table.sv
`timescale 1ns/1ps
module test_rat_ckpt_table;

    localparam int NA = 32;
    localparam int PW = 7;
    localparam int NR = 2;
    localparam int NWP = 2;
    localparam int NC = 4;
    localparam int AW = 5;
    localparam int IW = 2;
    localparam int CW = 3;

    typedef struct packed {
        logic [1:0] we;
        logic [4:0] wa0;
        logic [6:0] wp0;
        logic [4:0] wa1;
        logic [6:0] wp1;
        logic       take;
        logic       rel;
        logic       rs;
        logic [1:0] ridx;
        logic [4:0] ra;
        logic [6:0] exp_rd;
        logic [2:0] exp_cnt;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VEC [NV] = '{
        '{2'b01, 5'd5, 7'd40,  5'd0, 7'd0,  1'b0, 1'b0, 1'b0, 2'd0, 5'd5, 7'd40,  3'd0, 4'd3}, // R3 single write
        '{2'b11, 5'd5, 7'd41,  5'd5, 7'd42, 1'b0, 1'b0, 1'b0, 2'd0, 5'd5, 7'd42,  3'd0, 4'd3}, // R3 port priority
        '{2'b01, 5'd6, 7'd50,  5'd0, 7'd0,  1'b1, 1'b0, 1'b0, 2'd0, 5'd6, 7'd50,  3'd1, 4'd4},
        '{2'b01, 5'd5, 7'd60,  5'd0, 7'd0,  1'b1, 1'b0, 1'b0, 2'd0, 5'd5, 7'd60,  3'd2, 4'd4},
        '{2'b01, 5'd6, 7'd70,  5'd0, 7'd0,  1'b0, 1'b0, 1'b0, 2'd0, 5'd6, 7'd70,  3'd2, 4'd3},
        '{2'b01, 5'd5, 7'd99,  5'd0, 7'd0,  1'b0, 1'b0, 1'b1, 2'd0, 5'd5, 7'd60,  3'd1, 4'd6}, // R6 write blocked
        '{2'b00, 5'd0, 7'd0,   5'd0, 7'd0,  1'b0, 1'b0, 1'b0, 2'd0, 5'd6, 7'd50,  3'd1, 4'd6},
        '{2'b01, 5'd7, 7'd80,  5'd0, 7'd0,  1'b1, 1'b0, 1'b0, 2'd0, 5'd7, 7'd80,  3'd2, 4'd4},
        '{2'b01, 5'd7, 7'd81,  5'd0, 7'd0,  1'b0, 1'b0, 1'b0, 2'd0, 5'd7, 7'd81,  3'd2, 4'd3},
        '{2'b00, 5'd0, 7'd0,   5'd0, 7'd0,  1'b0, 1'b0, 1'b1, 2'd1, 5'd5, 7'd42,  3'd0, 4'd6}, // R6 older rank
        '{2'b00, 5'd0, 7'd0,   5'd0, 7'd0,  1'b0, 1'b0, 1'b0, 2'd0, 5'd7, 7'd7,   3'd0, 4'd6},
        '{2'b01, 5'd7, 7'd90,  5'd0, 7'd0,  1'b0, 1'b0, 1'b1, 2'd0, 5'd7, 7'd90,  3'd0, 4'd7}, // R7 invalid rank
        '{2'b00, 5'd0, 7'd0,   5'd0, 7'd0,  1'b0, 1'b1, 1'b0, 2'd0, 5'd7, 7'd90,  3'd0, 4'd8}, // R8 empty release
        '{2'b01, 5'd8, 7'd100, 5'd0, 7'd0,  1'b1, 1'b0, 1'b0, 2'd0, 5'd8, 7'd100, 3'd1, 4'd4},
        '{2'b01, 5'd8, 7'd101, 5'd0, 7'd0,  1'b1, 1'b0, 1'b0, 2'd0, 5'd8, 7'd101, 3'd2, 4'd4},
        '{2'b01, 5'd8, 7'd102, 5'd0, 7'd0,  1'b1, 1'b0, 1'b0, 2'd0, 5'd8, 7'd102, 3'd3, 4'd4},
        '{2'b01, 5'd8, 7'd103, 5'd0, 7'd0,  1'b1, 1'b0, 1'b0, 2'd0, 5'd8, 7'd103, 3'd4, 4'd5}, // R5 becomes full
        '{2'b01, 5'd8, 7'd104, 5'd0, 7'd0,  1'b1, 1'b0, 1'b0, 2'd0, 5'd8, 7'd104, 3'd4, 4'd5}, // R5 take blocked
        '{2'b00, 5'd0, 7'd0,   5'd0, 7'd0,  1'b0, 1'b1, 1'b0, 2'd0, 5'd8, 7'd104, 3'd3, 4'd8},
        '{2'b00, 5'd0, 7'd0,   5'd0, 7'd0,  1'b0, 1'b0, 1'b1, 2'd2, 5'd8, 7'd101, 3'd0, 4'd8}, // R8 ranks kept
        '{2'b01, 5'd9, 7'd110, 5'd0, 7'd0,  1'b1, 1'b0, 1'b0, 2'd0, 5'd9, 7'd110, 3'd1, 4'd4},
        '{2'b01, 5'd9, 7'd111, 5'd0, 7'd0,  1'b1, 1'b0, 1'b0, 2'd0, 5'd9, 7'd111, 3'd2, 4'd4},
        '{2'b01, 5'd9, 7'd112, 5'd0, 7'd0,  1'b1, 1'b0, 1'b0, 2'd0, 5'd9, 7'd112, 3'd3, 4'd4},
        '{2'b01, 5'd9, 7'd113, 5'd0, 7'd0,  1'b0, 1'b0, 1'b0, 2'd0, 5'd9, 7'd113, 3'd3, 4'd3},
        '{2'b00, 5'd0, 7'd0,   5'd0, 7'd0,  1'b0, 1'b1, 1'b1, 2'd0, 5'd9, 7'd112, 3'd1, 4'd9}, // R9
        '{2'b00, 5'd0, 7'd0,   5'd0, 7'd0,  1'b0, 1'b0, 1'b1, 2'd0, 5'd9, 7'd111, 3'd0, 4'd9},
        '{2'b01, 5'd9, 7'd120, 5'd0, 7'd0,  1'b1, 1'b1, 1'b0, 2'd0, 5'd9, 7'd120, 3'd1, 4'd8},
        '{2'b01, 5'd9, 7'd121, 5'd0, 7'd0,  1'b1, 1'b1, 1'b0, 2'd0, 5'd9, 7'd121, 3'd1, 4'd8}, // R8 take+release
        '{2'b01, 5'd9, 7'd122, 5'd0, 7'd0,  1'b0, 1'b0, 1'b0, 2'd0, 5'd9, 7'd122, 3'd1, 4'd3},
        '{2'b00, 5'd0, 7'd0,   5'd0, 7'd0,  1'b0, 1'b0, 1'b1, 2'd0, 5'd9, 7'd121, 3'd0, 4'd8}
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NR*AW-1:0]  rd_arch;
    logic [NR*PW-1:0]  rd_phys;
    logic [NWP-1:0]    wr_en;
    logic [NWP*AW-1:0] wr_arch;
    logic [NWP*PW-1:0] wr_phys;
    logic              ckpt_take;
    logic              ckpt_release;
    logic              restore_en;
    logic [IW-1:0]     restore_idx;
    logic              ckpt_full;
    logic [CW-1:0]     ckpt_count;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rat_ckpt_table #(
        .NUM_ARCH(NA), .PW(PW), .NUM_RD(NR), .NUM_WR(NWP), .NUM_CKPT(NC)
    ) i_rat_ckpt_table (
        .clk(clk), .rst_n(rst_n), .rd_arch(rd_arch), .rd_phys(rd_phys),
        .wr_en(wr_en), .wr_arch(wr_arch), .wr_phys(wr_phys),
        .ckpt_take(ckpt_take), .ckpt_release(ckpt_release),
        .restore_en(restore_en), .restore_idx(restore_idx),
        .ckpt_full(ckpt_full), .ckpt_count(ckpt_count)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = '0; wr_arch = '0; wr_phys = '0;
        ckpt_take = 1'b0; ckpt_release = 1'b0;
        restore_en = 1'b0; restore_idx = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic check_identity();
        for (int i = 0; i < NA; i += 2) begin
            rd_arch = {5'(i + 1), 5'(i)};
            #1;
            check("R1", "entry even", int'(rd_phys[PW-1:0]), i);
            check("R1", "entry odd", int'(rd_phys[2*PW-1:PW]), i + 1);
        end
        check("R1", "count", int'(ckpt_count), 0);
        check("R1", "full", int'(ckpt_full), 0);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        rd_arch = '0;
        idle();
        do_reset();
        check_identity();

        // R2: same-cycle write is not seen until after the edge.
        @(negedge clk);
        wr_en = 2'b01; wr_arch = {5'd0, 5'd10}; wr_phys = {7'd0, 7'd55};
        rd_arch = {5'd0, 5'd10};
        #1;
        check("R2", "read before edge", int'(rd_phys[PW-1:0]), 10);
        @(posedge clk);
        #1;
        check("R2", "read after edge", int'(rd_phys[PW-1:0]), 55);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            wr_en        = VEC[v].we;
            wr_arch      = {VEC[v].wa1, VEC[v].wa0};
            wr_phys      = {VEC[v].wp1, VEC[v].wp0};
            ckpt_take    = VEC[v].take;
            ckpt_release = VEC[v].rel;
            restore_en   = VEC[v].rs;
            restore_idx  = VEC[v].ridx;
            rd_arch      = {5'd0, VEC[v].ra};
            @(posedge clk);
            #1;
            idle();
            check($sformatf("R%0d", VEC[v].req), $sformatf("vec %0d read", v),
                  int'(rd_phys[PW-1:0]), int'(VEC[v].exp_rd));
            check($sformatf("R%0d", VEC[v].req), $sformatf("vec %0d count", v),
                  int'(ckpt_count), int'(VEC[v].exp_cnt));
            check("R5", $sformatf("vec %0d full", v),
                  int'(ckpt_full), (VEC[v].exp_cnt == 3'd4) ? 1 : 0);
        end

        // R1: reset in the middle of activity restores identity map.
        @(negedge clk);
        ckpt_take = 1'b1; wr_en = 2'b10; wr_arch = {5'd3, 5'd0}; wr_phys = {7'd77, 7'd0};
        @(negedge clk);
        idle();
        do_reset();
        check_identity();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule